// File: doc/BRIEF.md
# SRAM Self-Test Scan Register Wrapper

This block places an on-chip SRAM self-test engine behind a scan-accessible test data register. A TAP controller supplies a free-running test clock plus capture, shift and update strobes. The block turns serial scan data into staged control signals for the test engine (enable and mode), and returns the engine's done and fail status on TDO. The test engine itself is outside the block.

The register has two segments. The control segment holds the staged enable, mode, a control-source select and a segment-insert bit. Its enable bit sits nearest TDO. The diagnostic segment holds the failing address and data reported by the engine. It sits between TDI and the control segment, but only while the segment-insert bit is set. Otherwise TDI feeds the control segment directly, so routine control scans stay short.

The control-source select chooses who drives the engine. Either a CPU write port drives it, or the staged scan values do. The select takes effect one full test-clock cycle after the update that wrote it. As a result, one scan can set enable, mode and source together without a mixed state reaching the engine. A parameter selects a second clocking style for TAPs that use gated clocks: the shift cells run on an internally gated test clock and the update stage loads on the falling edge.

Top module: `sram_bist_tdr_wrap`

## Requirements
- R1: When `tlr_n` is low at a rising `tck` edge, the block resets. `bist_enable`, `bist_mode` and `ctl_src_scan` become 0, the CPU write register clears, and the diagnostic segment is removed from the scan path.
- R2: A capture loads the control segment. Counting from TDO it holds: bit 0 staged enable, bits MODE_W..1 staged mode, bit MODE_W+1 source select, bit MODE_W+2 segment insert, then `bist_done`, then `bist_fail`. Each shift-enabled edge moves the path one bit toward TDO, and TDI enters at the far end.
- R3: The staged enable is the first bit on `tdo` after a capture. The bit that ends at position 0 of the control segment when the update comes becomes the staged enable.
- R4: Staged values and the outputs `bist_enable`, `bist_mode` and `ctl_src_scan` never change during capture or shift cycles. Staged values change only on an update.
- R5: `ctl_src_scan` (1 = scan drives the engine, 0 = CPU) takes its new staged value one full `tck` cycle after the update edge.
- R6: A single scan can write enable, mode and source select=1. In the cycle after the update, the outputs still show the CPU values. On the next edge they switch to all the scan values at once.
- R7: While the CPU is the source, `bist_enable` and `bist_mode` follow the CPU register. That register loads `cpu_enable` and `cpu_mode` at the edge where `cpu_we` is high. Scan updates do not move these outputs.
- R8: With the insert bit staged at 1, the scan path is CTRL_W + ADDR_W + DATA_W bits long (7 + 29 = 36 at defaults). With it at 0, the path is CTRL_W bits long (7 at defaults).
- R9: A change of the insert bit takes effect only after its update. The scan that writes the bit still uses the old path length.
- R10: When the diagnostic segment is in the path, a capture loads `fail_addr` and then `fail_data` into it. They appear on TDO after the control bits, in the order `fail_addr` LSB first, then `fail_data` LSB first.
- R11: With GATED_TCK = 1, the same strobe sequence produces the same scan-out data and, once settled, the same outputs as with GATED_TCK = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Free-running test clock |
| tlr_n | input | 1 | Synchronous active-low test-logic reset |
| capture_en | input | 1 | Capture strobe for this register |
| shift_en | input | 1 | Shift strobe for this register |
| update_en | input | 1 | Update strobe for this register |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| cpu_we | input | 1 | CPU write strobe for enable and mode |
| cpu_enable | input | 1 | CPU-side enable value |
| cpu_mode | input | MODE_W | CPU-side mode value |
| bist_done | input | 1 | Test engine finished |
| bist_fail | input | 1 | Test engine found a failure |
| fail_addr | input | ADDR_W | Failing address from the engine |
| fail_data | input | DATA_W | Failing data from the engine |
| bist_enable | output | 1 | Active enable to the engine |
| bist_mode | output | MODE_W | Active mode to the engine |
| ctl_src_scan | output | 1 | Active control source, 1 = scan, 0 = CPU |

## Verification
The bench targets the single-scan hand-over from CPU to scan control. A design without the extra delay stage would show the new source with stale or half-written values for one cycle, and the check in that cycle catches it. The bench measures path length with marker bits before and after the insert bit changes. A design that applied the insert bit at once, or that wired the diagnostic segment on the wrong side, would return the markers at the wrong offset. The bench also writes through the scan path while the CPU is the source and checks that the engine's outputs do not move. It runs the gated-clock variant beside the default one and compares their scan-out data and settled outputs.

// File: rtl/bsw_pkg.sv
// Shared definitions for the SRAM self-test scan register wrapper.
// Assumes the staged field set is enable, mode, source select and segment insert.
package bsw_pkg;

    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_SCAN = 1'b1
    } ctl_src_e;

    // Capture-only status bits appended above the staged fields (done, fail).
    localparam int unsigned STAT_BITS = 2;

    // Width of the staged fields: enable + mode + source select + insert.
    function automatic int unsigned stage_width(input int unsigned mode_w);
        return mode_w + 3;
    endfunction

endpackage

// File: rtl/bsw_shift_seg.sv
// Capture/shift cell chain for one scan segment.
// Bit 0 is nearest the serial output; si enters at bit W-1.
// Assumes W >= 2 and that cap and shf are never high together.
// GATED=0: cells run on the free-running clock with strobe enables.
// GATED=1: cells run on a clock gated by a low-phase latch of the strobes.
module bsw_shift_seg #(
    parameter int unsigned W     = 8,
    parameter bit          GATED = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         shf,
    input  logic         si,
    input  logic [W-1:0] cap_val,
    output logic         so,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    // Next cell contents: shift toward bit 0, or parallel capture.
    always_comb begin
        if (shf) begin
            nxt = {si, q[W-1:1]};
        end else begin
            nxt = cap_val;
        end
    end

    generate
        if (GATED) begin : g_gated
            logic gate;
            logic dclk;

            // Hold the gate open only while a strobe or reset is active; sampled in the low phase.
            always_latch begin
                if (!clk) begin
                    gate <= cap | shf | ~rst_n;
                end
            end

            assign dclk = clk & gate;

            // Cells clocked only when gated clock pulses.
            always_ff @(posedge dclk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end else begin : g_sync
            // Cells load on the free-running clock when a strobe is present.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (cap | shf) begin
                    q <= nxt;
                end
            end

            p_idle_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
                (!cap && !shf) |=> $stable(q))
                else $error("shift cells moved without a strobe");

            p_strobe_excl_r2 : assert property (@(posedge clk) disable iff (!rst_n)
                !(cap && shf))
                else $error("capture and shift together");
        end
    endgenerate

    assign so = q[0];

endmodule

// File: rtl/bsw_update_stage.sv
// Update register that holds staged values between scans.
// NEG=1 loads on the falling clock edge (gated-clock TAP style).
// Assumes upd is high for one cycle per scan, after the shifting ends.
module bsw_update_stage #(
    parameter int unsigned   W   = 4,
    parameter logic [W-1:0]  RST = '0,
    parameter bit            NEG = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic uclk;

    generate
        if (NEG) begin : g_neg
            assign uclk = ~clk;
        end else begin : g_pos
            assign uclk = clk;
        end
    endgenerate

    // Load staged values only on update; reset to the disabled word.
    always_ff @(posedge uclk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (upd) begin
            q <= d;
        end
    end

    p_reset_val_r1 : assert property (@(posedge uclk)
        !rst_n |=> (q == RST))
        else $error("staged value not at reset word");

    p_upd_only_r4 : assert property (@(posedge uclk) disable iff (!rst_n)
        !upd |=> $stable(q))
        else $error("staged value changed without update");

endmodule

// File: rtl/bsw_src_mux.sv
// Control-source select with one extra clock of delay after update,
// and the mux that hands enable/mode to the engine from CPU or scan.
// Assumes stg_* come from the update stage clocked on the same edge.
module bsw_src_mux
    import bsw_pkg::*;
#(
    parameter int unsigned MODE_W = 2,
    parameter bit          NEG    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_sel,
    input  logic              stg_en,
    input  logic [MODE_W-1:0] stg_mode,
    input  logic              cpu_en,
    input  logic [MODE_W-1:0] cpu_mode,
    output logic              act_en,
    output logic [MODE_W-1:0] act_mode,
    output logic              src_scan
);

    logic     uclk;
    ctl_src_e src_q;

    generate
        if (NEG) begin : g_neg
            assign uclk = ~clk;
        end else begin : g_pos
            assign uclk = clk;
        end
    endgenerate

    // Delay the staged select by one full clock so other fields settle first.
    always_ff @(posedge uclk) begin
        if (!rst_n) begin
            src_q <= SRC_CPU;
        end else begin
            src_q <= stg_sel ? SRC_SCAN : SRC_CPU;
        end
    end

    // Route the selected source to the engine.
    always_comb begin
        if (src_q == SRC_SCAN) begin
            act_en   = stg_en;
            act_mode = stg_mode;
        end else begin
            act_en   = cpu_en;
            act_mode = cpu_mode;
        end
    end

    assign src_scan = (src_q == SRC_SCAN);

    p_src_lag_r5 : assert property (@(posedge uclk) disable iff (!rst_n)
        $rose(stg_sel) |-> !src_scan)
        else $error("source switched in the update cycle");

    p_switch_settled_r6 : assert property (@(posedge uclk) disable iff (!rst_n)
        $rose(src_scan) |-> $stable({stg_en, stg_mode}))
        else $error("staged fields moved at source switch");

endmodule

// File: rtl/sram_bist_tdr_wrap.sv
// Top of the scan register wrapper around the SRAM self-test engine.
// Scan path: tdi -> [diagnostic segment if inserted] -> control segment -> tdo.
// Assumes strobes are already qualified for this register by the TAP.
// The CPU write port is synchronous to tck.
module sram_bist_tdr_wrap
    import bsw_pkg::*;
#(
    parameter bit          GATED_TCK = 1'b0,
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned DATA_W    = 16
) (
    input  logic              tck,
    input  logic              tlr_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              tdi,
    output logic              tdo,
    input  logic              cpu_we,
    input  logic              cpu_enable,
    input  logic [MODE_W-1:0] cpu_mode,
    input  logic              bist_done,
    input  logic              bist_fail,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic [DATA_W-1:0] fail_data,
    output logic              bist_enable,
    output logic [MODE_W-1:0] bist_mode,
    output logic              ctl_src_scan
);

    localparam int unsigned STG_W   = stage_width(MODE_W);
    localparam int unsigned CTRL_W  = STG_W + STAT_BITS;
    localparam int unsigned DIAG_W  = ADDR_W + DATA_W;
    localparam int unsigned EN_BIT  = 0;
    localparam int unsigned MUX_BIT = MODE_W + 1;
    localparam int unsigned SEG_BIT = MODE_W + 2;

    logic [STG_W-1:0]  stg_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIAG_W-1:0] diag_q;
    logic              seg_ins;
    logic              diag_so;
    logic              ctrl_si;
    logic              cpu_en_q;
    logic [MODE_W-1:0] cpu_mode_q;

    assign seg_ins = stg_q[SEG_BIT];
    assign ctrl_si = seg_ins ? diag_so : tdi;

    // CPU-side control register, written by the CPU port.
    always_ff @(posedge tck) begin
        if (!tlr_n) begin
            cpu_en_q   <= 1'b0;
            cpu_mode_q <= '0;
        end else if (cpu_we) begin
            cpu_en_q   <= cpu_enable;
            cpu_mode_q <= cpu_mode;
        end
    end

    bsw_shift_seg #(
        .W     (DIAG_W),
        .GATED (GATED_TCK)
    ) u_diag (
        .clk     (tck),
        .rst_n   (tlr_n),
        .cap     (capture_en & seg_ins),
        .shf     (shift_en & seg_ins),
        .si      (tdi),
        .cap_val ({fail_data, fail_addr}),
        .so      (diag_so),
        .q       (diag_q)
    );

    bsw_shift_seg #(
        .W     (CTRL_W),
        .GATED (GATED_TCK)
    ) u_ctrl (
        .clk     (tck),
        .rst_n   (tlr_n),
        .cap     (capture_en),
        .shf     (shift_en),
        .si      (ctrl_si),
        .cap_val ({bist_fail, bist_done, stg_q}),
        .so      (tdo),
        .q       (ctrl_q)
    );

    bsw_update_stage #(
        .W   (STG_W),
        .RST ('0),
        .NEG (GATED_TCK)
    ) u_stage (
        .clk   (tck),
        .rst_n (tlr_n),
        .upd   (update_en),
        .d     (ctrl_q[STG_W-1:0]),
        .q     (stg_q)
    );

    bsw_src_mux #(
        .MODE_W (MODE_W),
        .NEG    (GATED_TCK)
    ) u_src (
        .clk      (tck),
        .rst_n    (tlr_n),
        .stg_sel  (stg_q[MUX_BIT]),
        .stg_en   (stg_q[EN_BIT]),
        .stg_mode (stg_q[MODE_W:1]),
        .cpu_en   (cpu_en_q),
        .cpu_mode (cpu_mode_q),
        .act_en   (bist_enable),
        .act_mode (bist_mode),
        .src_scan (ctl_src_scan)
    );

    p_strobes_r4 : assert property (@(posedge tck) disable iff (!tlr_n)
        $onehot0({capture_en, shift_en, update_en}))
        else $error("more than one scan strobe");

    p_seg_stable_r9 : assert property (@(posedge tck) disable iff (!tlr_n)
        shift_en |-> $stable(seg_ins))
        else $error("path length changed during shift");

    generate
        if (!GATED_TCK) begin : g_sync_chk
            p_cpu_hold_r7 : assert property (@(posedge tck) disable iff (!tlr_n)
                (!ctl_src_scan && !stg_q[MUX_BIT] && !cpu_we) |=> $stable({bist_enable, bist_mode}))
                else $error("engine controls moved while CPU holds them");

            p_stat_capture_r2 : assert property (@(posedge tck) disable iff (!tlr_n)
                $past(capture_en) |-> (ctrl_q[CTRL_W-1:STG_W] == $past({bist_fail, bist_done})))
                else $error("status bits not captured");

            p_diag_capture_r10 : assert property (@(posedge tck) disable iff (!tlr_n)
                $past(capture_en && seg_ins) |-> (diag_q == $past({fail_data, fail_addr})))
                else $error("diagnostic segment not captured");
        end
    endgenerate

endmodule

// File: tb/tb_sram_bist_tdr_wrap.sv
module tb_sram_bist_tdr_wrap;

    localparam int CLK_P  = 10;
    localparam int MODE_W = 2;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 16;
    localparam int NVEC   = 6;

    // Vector fields: [8] src select, [7:6] mode, [5] enable, [4] done, [3] fail,
    // [2] cpu enable, [1:0] cpu mode
    localparam logic [8:0] VEC [NVEC] = '{
        9'b001100110,
        9'b110110001,
        9'b111011100,
        9'b000001011,
        9'b101100000,
        9'b010111101
    };

    logic tck = 1'b0;
    logic tlr_n, capture_en, shift_en, update_en, tdi, cpu_we, cpu_enable;
    logic [MODE_W-1:0] cpu_mode;
    logic bist_done, bist_fail;
    logic [ADDR_W-1:0] fail_addr;
    logic [DATA_W-1:0] fail_data;
    logic tdo0, en0, src0, tdo1, en1, src1;
    logic [MODE_W-1:0] mode0, mode1;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) tck = ~tck;

    sram_bist_tdr_wrap #(.GATED_TCK(1'b0)) dut (
        .tck(tck), .tlr_n(tlr_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo0), .cpu_we(cpu_we),
        .cpu_enable(cpu_enable), .cpu_mode(cpu_mode), .bist_done(bist_done),
        .bist_fail(bist_fail), .fail_addr(fail_addr), .fail_data(fail_data),
        .bist_enable(en0), .bist_mode(mode0), .ctl_src_scan(src0)
    );

    sram_bist_tdr_wrap #(.GATED_TCK(1'b1)) dut_g (
        .tck(tck), .tlr_n(tlr_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo1), .cpu_we(cpu_we),
        .cpu_enable(cpu_enable), .cpu_mode(cpu_mode), .bist_done(bist_done),
        .bist_fail(bist_fail), .fail_addr(fail_addr), .fail_data(fail_data),
        .bist_enable(en1), .bist_mode(mode1), .ctl_src_scan(src1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck);
        #1;
    endtask

    task automatic cpu_write(input logic e, input logic [MODE_W-1:0] m);
        cpu_we = 1'b1; cpu_enable = e; cpu_mode = m;
        cyc();
        cpu_we = 1'b0;
    endtask

    // One capture, len shifts, one update; returns scan-out of both instances.
    task automatic scan(input logic [63:0] din, input int len,
                        output logic [63:0] d0, output logic [63:0] d1);
        logic [7:0] snap;
        bit ok;
        ok = 1'b1;
        d0 = '0;
        d1 = '0;
        snap = {en0, mode0, src0, en1, mode1, src1};
        capture_en = 1'b1;
        cyc();
        capture_en = 1'b0;
        shift_en = 1'b1;
        for (int i = 0; i < len; i++) begin
            d0[i] = tdo0;
            d1[i] = tdo1;
            tdi = din[i];
            cyc();
            if ({en0, mode0, src0, en1, mode1, src1} !== snap) ok = 1'b0;
        end
        shift_en = 1'b0;
        update_en = 1'b1;
        cyc();
        update_en = 1'b0;
        chk("R4 outputs held during shift", {63'd0, ok}, 64'd1);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] d0, d1;
        logic [6:0] prev, cw, c2, c3;
        logic exp_en;
        logic [MODE_W-1:0] exp_mode;

        tlr_n = 1'b0; capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
        tdi = 1'b0; cpu_we = 1'b0; cpu_enable = 1'b0; cpu_mode = '0;
        bist_done = 1'b0; bist_fail = 1'b0; fail_addr = '0; fail_data = '0;
        repeat (3) cyc();
        tlr_n = 1'b1;
        cyc();

        // R1: reset state of both variants
        chk("R1 reset outputs", {en0, mode0, src0}, '0);
        chk("R1 reset outputs gated", {en1, mode1, src1}, '0);

        // Table walk: each vector is one control scan of 7 bits
        prev = '0;
        for (int v = 0; v < NVEC; v++) begin
            logic [8:0] t;
            t = VEC[v];
            cpu_write(t[2], t[1:0]);
            bist_done = t[4];
            bist_fail = t[3];
            cw = {3'b000, t[8], t[7:6], t[5]};
            scan({57'd0, cw}, 7, d0, d1);
            // R2/R3: capture word, staged enable first on tdo
            chk("R2 control capture", d0[6:0], {t[3], t[4], 1'b0, prev[3:0]});
            chk("R3 enable first on tdo", {63'd0, d0[0]}, {63'd0, prev[0]});
            chk("R11 gated scan-out", d1[6:0], d0[6:0]);
            // R5/R6: in the cycle after update the old source still rules
            chk("R5 source one cycle late", {63'd0, src0}, {63'd0, prev[3]});
            exp_en   = prev[3] ? t[5] : t[2];
            exp_mode = prev[3] ? t[7:6] : t[1:0];
            chk("R6 controls before switch", {en0, mode0}, {exp_en, exp_mode});
            cyc();
            exp_en   = t[8] ? t[5] : t[2];
            exp_mode = t[8] ? t[7:6] : t[1:0];
            chk("R6 R7 controls after switch", {en0, mode0, src0}, {exp_en, exp_mode, t[8]});
            cyc();
            chk("R11 gated settled outputs", {en1, mode1, src1}, {en0, mode0, src0});
            prev = cw;
        end

        // R7: CPU source; CPU write moves outputs, scan write does not
        cpu_write(1'b0, 2'b11);
        chk("R7 cpu write applied", {en0, mode0, src0}, {1'b0, 2'b11, 1'b0});
        scan({57'd0, 7'b0000011}, 7, d0, d1);
        cyc();
        cyc();
        chk("R7 scan ignored under cpu", {en0, mode0, src0}, {1'b0, 2'b11, 1'b0});
        chk("R7 scan ignored under cpu gated", {en1, mode1, src1}, {1'b0, 2'b11, 1'b0});

        // R8/R9: write the insert bit; this scan is still 7 bits long
        cw = 7'b0010000;
        scan({50'd0, cw, cw}, 14, d0, d1);
        chk("R2 capture before insert", d0[6:0], 7'b1100011);
        chk("R9 old length during insert scan", d0[13:7], cw);
        chk("R11 gated insert scan", d1[13:0], d0[13:0]);
        cyc();
        cyc();

        // R8/R10: inserted path of 36 bits, diagnostic content after control
        fail_addr = 13'h1A5C;
        fail_data = 16'hBEEF;
        c2 = 7'b0000101;
        scan({53'd0, c2, 4'b1010}, 40, d0, d1);
        chk("R2 capture with insert", d0[6:0], 7'b1110000);
        chk("R10 failing address", d0[19:7], {51'd0, fail_addr});
        chk("R10 failing data", d0[35:20], {48'd0, fail_data});
        chk("R8 inserted length 36", d0[39:36], 4'b1010);
        chk("R11 gated inserted scan", d1[39:0], d0[39:0]);
        cyc();
        cyc();

        // R8/R9: insert cleared by previous update, path back to 7 bits
        c3 = 7'b0001011;
        scan({50'd0, c3, c3}, 14, d0, d1);
        chk("R8 bypass capture", d0[6:0], 7'b1100101);
        chk("R8 bypass length 7", d0[13:7], c3);
        cyc();
        cyc();
        chk("R6 scan source settled", {en0, mode0, src0}, {1'b1, 2'b01, 1'b1});
        chk("R11 gated scan source", {en1, mode1, src1}, {1'b1, 2'b01, 1'b1});

        // R1: reset in the middle of operation
        tlr_n = 1'b0;
        cyc();
        tlr_n = 1'b1;
        cyc();
        chk("R1 mid-run reset", {en0, mode0, src0}, '0);
        chk("R1 mid-run reset gated", {en1, mode1, src1}, '0);
        scan({50'd0, 7'b0000001, 7'b0000001}, 14, d0, d1);
        chk("R1 reset leaves 7-bit path", d0[13:7], 7'b0000001);
        chk("R1 reset staged word", d0[4:0], 5'b00000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule